// File: doc/BRIEF.md
# I2C Target Register Layer

This block is the register layer of an I2C target device. It sits behind a byte-level I2C engine that reports bus events as single-cycle strobes: start (including a repeated start), address match with the transfer direction, each received byte, each byte the master requests, and stop. The first byte of a write transfer selects a register. The block then serves multi-byte reads and writes from a small register map. The map holds a command data window, a data-window length, a status word, a device-address setting, a bus-speed setting, a derived maximum clock rate and a warm-reset trigger.

The block drives three outputs. The engine compares the seven-bit device address against its bus address. The warm-reset output is a one-cycle pulse. The speed-mode output shows the current bus speed setting. Address and speed settings can be written as either volatile or persistent. A persistent value is kept in a shadow register that stands in for non-volatile storage. A warm reset reloads the live settings from these shadows. Settings written in a transfer take effect only when that transfer ends, so the transfer in flight finishes under the old configuration.

Top module: `i2c_tgt_regfile`

## Requirements
- R1: The first byte written after a write-direction address match sets the register pointer. The pointer stays set for later transfers, including a repeated-start read and a fresh read transfer. The byte position restarts at each address match. Multi-byte values move most significant byte first.
- R2: When the pointer is 0x80, every further written byte appears on `dataWrByte` with `dataWrValid` high in the cycle of `evWrByte`. Every read request raises `dataRdReq` in the same cycle and returns `dataRdByte` on `rdByte`.
- R3: Register 0x81 (2 bytes) holds the data-window length, reset value 0x0115. A written value below 0x0010 is stored as 0x0010. A value above 0x0115 is stored as 0x0115. Reading the register returns the stored value.
- R4: `devAddr`, `speedMode` and the stored length change only in the cycle after a stop or start event that ends a write transfer, or after a warm-reset pulse. They never change in the middle of a transfer.
- R5: Register 0x83 (2 bytes, write only) puts bits 6:0 on `devAddr`. When bit 15 is set, the value is also kept as the persistent address. The reset address is 0x20.
- R6: A write of at least one data byte to 0x88 raises `softReset` for exactly one cycle, in the cycle after the transfer ends. In the following cycle, `devAddr` and `speedMode` reload from their persistent values and the length returns to 0x0115.
- R7: Register 0x82 (4 bytes, read only) reads as follows: bit 31 is `cmdBusy`, bit 30 is `respReady`, bits 27:24 are all ones (capabilities), bits 15:0 are `respLen`, and all other bits are 0.
- R8: Register 0x89 (2 bytes) has a mode field in bits 2:0. The codes are 001 Sm, 010 Fm, 011 Sm+Fm and 100 Fm+. The reset value is 011. A write with any other code is ignored entirely. Bit 15 set also stores the code as persistent. Bit 15 always reads 0.
- R9: Register 0x84 (4 bytes) reads a clock rate in kHz that depends on the mode: 100 for 001, 400 for 010 and 011, and 1000 for 100.
- R10: Reads return 0xFF for the write-only registers 0x83 and 0x88, for unimplemented addresses such as 0x85, and for any byte past a register's width.
- R11: Writes to read-only or unimplemented registers, and writes that carry fewer bytes than the register width, change nothing.
- R12: After reset, `devAddr` is 0x20, `speedMode` is 011 and `softReset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| evStart | input | 1 | Start or repeated start seen |
| evAddrMatch | input | 1 | Own address matched |
| evRead | input | 1 | Direction for evAddrMatch, 1 = read |
| evWrByte | input | 1 | A byte was received |
| wrByte | input | 8 | Received byte |
| evRdReq | input | 1 | Master requests a byte |
| evStop | input | 1 | Stop seen |
| rdByte | output | 8 | Byte to return, valid in the evRdReq cycle |
| devAddr | output | 7 | Address the engine matches |
| softReset | output | 1 | Warm-reset pulse |
| speedMode | output | 3 | Current speed mode code |
| dataWrValid | output | 1 | Data-window write strobe |
| dataWrByte | output | 8 | Data-window write byte |
| dataRdReq | output | 1 | Data-window read request |
| dataRdByte | input | 8 | Data-window read byte |
| cmdBusy | input | 1 | Command processor busy |
| respReady | input | 1 | Response ready |
| respLen | input | 16 | Pending response length |

## Verification
If the pointer or byte position is wrong, `rdByte` returns the wrong value on the very next read request. The data-window strobes would also fire for the wrong register in that same cycle. If an assembled or committed setting is corrupt, `devAddr` or `speedMode` shows it one cycle after the stop. A bad length or shadow value stays hidden until a later read of 0x81 or a warm reset exposes it. For that reason, the bench compares the registered outputs against a behavioural model on every clock and checks every read byte against it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int IDX_W = 3;

  localparam logic [7:0] REG_DATA  = 8'h80;
  localparam logic [7:0] REG_LEN   = 8'h81;
  localparam logic [7:0] REG_STATE = 8'h82;
  localparam logic [7:0] REG_BASE  = 8'h83;
  localparam logic [7:0] REG_FREQ  = 8'h84;
  localparam logic [7:0] REG_RESET = 8'h88;
  localparam logic [7:0] REG_MODE  = 8'h89;

  typedef enum logic [2:0] {
    MODE_SM   = 3'd1,
    MODE_FM   = 3'd2,
    MODE_SMFM = 3'd3,
    MODE_FMP  = 3'd4
  } speedCode_t;

  localparam logic [31:0] KHZ_SM  = 32'd100;
  localparam logic [31:0] KHZ_FM  = 32'd400;
  localparam logic [31:0] KHZ_FMP = 32'd1000;

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftIn;
    logic             commit;
    logic [7:0]       ptr;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;

  // bytes a write must carry before it is committed; 0 = not writable
  function automatic logic [IDX_W-1:0] wrWidth(input logic [7:0] p);
    case (p)
      REG_LEN, REG_BASE, REG_MODE: wrWidth = IDX_W'(2);
      REG_RESET:                   wrWidth = IDX_W'(1);
      default:                     wrWidth = '0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] rdWidth(input logic [7:0] p);
    case (p)
      REG_LEN, REG_MODE: rdWidth = IDX_W'(2);
      default:           rdWidth = IDX_W'(4);
    endcase
  endfunction

  function automatic logic modeLegal(input logic [2:0] m);
    modeLegal = (m == MODE_SM) || (m == MODE_FM) || (m == MODE_SMFM) || (m == MODE_FMP);
  endfunction

  function automatic logic [31:0] modeKhz(input logic [2:0] m);
    case (m)
      MODE_SM:  modeKhz = KHZ_SM;
      MODE_FMP: modeKhz = KHZ_FMP;
      default:  modeKhz = KHZ_FM;
    endcase
  endfunction
endpackage

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evStart,
  input  logic        evAddrMatch,
  input  logic        evRead,
  input  logic        evWrByte,
  input  logic [7:0]  wrByte,
  input  logic        evRdReq,
  input  logic        evStop,
  output ctrlStrobe_t strobe,
  output logic        dataWrValid,
  output logic        dataRdReq
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic             active;
  logic             readDir;
  logic             havePtr;
  logic [7:0]       ptr;
  logic [IDX_W-1:0] idx;

  logic endTxn, ptrByte, dataByte, readStep;

  always_comb begin
    endTxn   = (evStop || evStart) && active;
    ptrByte  = evWrByte && active && !readDir && !havePtr;
    dataByte = evWrByte && active && !readDir && havePtr;
    readStep = evRdReq && active && readDir;

    strobe.shiftIn = dataByte;
    strobe.commit  = endTxn && !readDir && havePtr;
    strobe.ptr     = ptr;
    strobe.idx     = idx;

    dataWrValid = dataByte && (ptr == REG_DATA);
    dataRdReq   = readStep && (ptr == REG_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      readDir <= 1'b0;
      havePtr <= 1'b0;
      ptr     <= REG_DATA;
      idx     <= '0;
    end else if (evStart || evStop) begin
      active  <= 1'b0;
      havePtr <= 1'b0;
      idx     <= '0;
    end else if (evAddrMatch) begin
      active  <= 1'b1;
      readDir <= evRead;
      havePtr <= 1'b0;
      idx     <= '0;
    end else if (ptrByte) begin
      ptr     <= wrByte;
      havePtr <= 1'b1;
      idx     <= '0;
    end else if ((dataByte || readStep) && idx != IDX_MAX) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tgt_dpath.sv
module i2c_tgt_dpath
  import i2c_tgt_pkg::*;
#(
  parameter int          LEN_W    = 16,
  parameter logic [6:0]  DEF_ADDR = 7'h20,
  parameter logic [LEN_W-1:0] MIN_LEN = 16'h0010,
  parameter logic [LEN_W-1:0] MAX_LEN = 16'h0115,
  parameter logic [3:0]  CAPS     = 4'hF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [7:0]       wrByte,
  input  logic             cmdBusy,
  input  logic             respReady,
  input  logic [15:0]      respLen,
  input  logic [7:0]       dataRdByte,
  output logic [6:0]       devAddr,
  output logic [2:0]       speedMode,
  output logic             softReset,
  output logic [7:0]       rdByte
);
  localparam int ASM_W = 16;

  logic [ASM_W-1:0] asmReg;
  logic [6:0]       addrAct, addrKeep;
  logic [2:0]       modeAct, modeKeep;
  logic [LEN_W-1:0] lenAct;
  logic             rstPulse;

  logic [IDX_W-1:0] wWidth, rWidth, pos;
  logic             complete;
  logic [LEN_W-1:0] lenClamped;
  logic [31:0]      word, shifted;

  always_comb begin
    wWidth   = wrWidth(strobe.ptr);
    complete = strobe.commit && (wWidth != '0) && (strobe.idx >= wWidth);
    if (asmReg[LEN_W-1:0] < MIN_LEN)      lenClamped = MIN_LEN;
    else if (asmReg[LEN_W-1:0] > MAX_LEN) lenClamped = MAX_LEN;
    else                                  lenClamped = asmReg[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg   <= '0;
      addrAct  <= DEF_ADDR;
      addrKeep <= DEF_ADDR;
      modeAct  <= MODE_SMFM;
      modeKeep <= MODE_SMFM;
      lenAct   <= MAX_LEN;
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= 1'b0;
      if (rstPulse) begin
        addrAct <= addrKeep;
        modeAct <= modeKeep;
        lenAct  <= MAX_LEN;
      end
      if (strobe.shiftIn && strobe.idx < wWidth)
        asmReg <= {asmReg[ASM_W-9:0], wrByte};
      if (complete) begin
        case (strobe.ptr)
          REG_LEN: lenAct <= lenClamped;
          REG_BASE: begin
            addrAct <= asmReg[6:0];
            if (asmReg[15]) addrKeep <= asmReg[6:0];
          end
          REG_MODE: begin
            if (modeLegal(asmReg[2:0])) begin
              modeAct <= asmReg[2:0];
              if (asmReg[15]) modeKeep <= asmReg[2:0];
            end
          end
          REG_RESET: rstPulse <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rWidth = rdWidth(strobe.ptr);
    case (strobe.ptr)
      REG_LEN:   word = 32'(lenAct);
      REG_STATE: word = {cmdBusy, respReady, 2'b00, CAPS, 8'h00, respLen};
      REG_FREQ:  word = modeKhz(modeAct);
      REG_MODE:  word = {29'd0, modeAct};
      default:   word = 32'hFFFF_FFFF;
    endcase
    pos     = rWidth - IDX_W'(1) - strobe.idx;
    shifted = word >> {pos[1:0], 3'b000};
    if (strobe.ptr == REG_DATA)    rdByte = dataRdByte;
    else if (strobe.idx >= rWidth) rdByte = 8'hFF;
    else                           rdByte = shifted[7:0];
  end

  assign devAddr   = addrAct;
  assign speedMode = modeAct;
  assign softReset = rstPulse;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEF_ADDR = 7'h20,
  parameter logic [15:0] MIN_LEN  = 16'h0010,
  parameter logic [15:0] MAX_LEN  = 16'h0115,
  parameter logic [3:0]  CAPS     = 4'hF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evStart,
  input  logic        evAddrMatch,
  input  logic        evRead,
  input  logic        evWrByte,
  input  logic [7:0]  wrByte,
  input  logic        evRdReq,
  input  logic        evStop,
  output logic [7:0]  rdByte,
  output logic [6:0]  devAddr,
  output logic        softReset,
  output logic [2:0]  speedMode,
  output logic        dataWrValid,
  output logic [7:0]  dataWrByte,
  output logic        dataRdReq,
  input  logic [7:0]  dataRdByte,
  input  logic        cmdBusy,
  input  logic        respReady,
  input  logic [15:0] respLen
);
  ctrlStrobe_t strobe;

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evAddrMatch(evAddrMatch),
    .evRead(evRead), .evWrByte(evWrByte), .wrByte(wrByte), .evRdReq(evRdReq),
    .evStop(evStop), .strobe(strobe), .dataWrValid(dataWrValid), .dataRdReq(dataRdReq)
  );

  i2c_tgt_dpath #(
    .LEN_W(16), .DEF_ADDR(DEF_ADDR), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CAPS(CAPS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte), .cmdBusy(cmdBusy),
    .respReady(respReady), .respLen(respLen), .dataRdByte(dataRdByte),
    .devAddr(devAddr), .speedMode(speedMode), .softReset(softReset), .rdByte(rdByte)
  );

  assign dataWrByte = wrByte;
endmodule

// File: rtl/i2c_tgt_regfile_chk.sv
module i2c_tgt_regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic       evStart,
  input logic       evStop,
  input logic       evWrByte,
  input logic       evRdReq,
  input logic [7:0] rdByte,
  input logic [6:0] devAddr,
  input logic       softReset,
  input logic [2:0] speedMode,
  input logic       dataWrValid,
  input logic       dataRdReq,
  input logic [7:0] dataRdByte
);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !softReset);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    softReset |-> $past(evStop || evStart));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!evStop && !evStart && !softReset) |=> $stable(devAddr));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!evStop && !evStart && !softReset) |=> $stable(speedMode));

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    evRdReq |-> (speedMode >= 3'd1 && speedMode <= 3'd4));

  assert_window_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataWrValid |-> evWrByte);

  assert_window_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataRdReq |-> (evRdReq && rdByte == dataRdByte));
endmodule

bind i2c_tgt_regfile i2c_tgt_regfile_chk u_chk (
  .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop), .evWrByte(evWrByte),
  .evRdReq(evRdReq), .rdByte(rdByte), .devAddr(devAddr), .softReset(softReset),
  .speedMode(speedMode), .dataWrValid(dataWrValid), .dataRdReq(dataRdReq),
  .dataRdByte(dataRdByte)
);

// File: tb/i2c_tgt_regfile_bench.sv
module i2c_tgt_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] LEN_MAX = 16'h0115;
  localparam logic [15:0] LEN_MIN = 16'h0010;

  logic clk = 0, rstN = 0;
  logic evStart = 0, evAddrMatch = 0, evRead = 0, evWrByte = 0, evRdReq = 0, evStop = 0;
  logic [7:0] wrByte = 0, dataRdByte = 0;
  logic cmdBusy = 0, respReady = 0;
  logic [15:0] respLen = 0;
  logic [7:0] rdByte, dataWrByte;
  logic [6:0] devAddr;
  logic softReset, dataWrValid, dataRdReq;
  logic [2:0] speedMode;

  int errors = 0, checks = 0;
  bit done = 0;

  i2c_tgt_regfile u_i2c_tgt_regfile (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evAddrMatch(evAddrMatch), .evRead(evRead),
    .evWrByte(evWrByte), .wrByte(wrByte), .evRdReq(evRdReq), .evStop(evStop),
    .rdByte(rdByte), .devAddr(devAddr), .softReset(softReset), .speedMode(speedMode),
    .dataWrValid(dataWrValid), .dataWrByte(dataWrByte), .dataRdReq(dataRdReq),
    .dataRdByte(dataRdByte), .cmdBusy(cmdBusy), .respReady(respReady), .respLen(respLen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit mAct, mRd, mHavePtr, mSoft;
  logic [7:0] mPtr;
  int mIdx;
  logic [7:0] wq[$];
  logic [6:0] mAddr, mAddrKeep;
  logic [2:0] mMode, mModeKeep;
  logic [15:0] mLen;

  task automatic modelCommit();
    logic [15:0] v;
    if (wq.size() >= 2) v = {wq[0], wq[1]}; else v = 16'h0;
    case (mPtr)
      8'h81: if (wq.size() >= 2) mLen = (v < LEN_MIN) ? LEN_MIN : ((v > LEN_MAX) ? LEN_MAX : v);
      8'h83: if (wq.size() >= 2) begin mAddr = v[6:0]; if (v[15]) mAddrKeep = v[6:0]; end
      8'h89: if (wq.size() >= 2 && v[2:0] >= 3'd1 && v[2:0] <= 3'd4) begin
               mMode = v[2:0]; if (v[15]) mModeKeep = v[2:0];
             end
      8'h88: if (wq.size() >= 1) mSoft = 1;
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct = 0; mRd = 0; mHavePtr = 0; mSoft = 0; mPtr = 8'h80; mIdx = 0; wq.delete();
      mAddr = 7'h20; mAddrKeep = 7'h20; mMode = 3'd3; mModeKeep = 3'd3; mLen = LEN_MAX;
    end else begin
      if (mSoft) begin mSoft = 0; mAddr = mAddrKeep; mMode = mModeKeep; mLen = LEN_MAX; end
      if (evStart || evStop) begin
        if (mAct && !mRd && mHavePtr) modelCommit();
        mAct = 0; mHavePtr = 0; mIdx = 0; wq.delete();
      end else if (evAddrMatch) begin
        mAct = 1; mRd = evRead; mHavePtr = 0; mIdx = 0; wq.delete();
      end else if (evWrByte && mAct && !mRd) begin
        if (!mHavePtr) begin mPtr = wrByte; mHavePtr = 1; end
        else wq.push_back(wrByte);
      end else if (evRdReq && mAct && mRd) begin
        mIdx++;
      end
    end
  end

  function automatic logic [7:0] expRd();
    logic [31:0] w; int n;
    n = 4;
    case (mPtr)
      8'h81: begin w = {16'h0, mLen}; n = 2; end
      8'h82: w = {cmdBusy, respReady, 2'b00, 4'hF, 8'h00, respLen};
      8'h84: w = (mMode == 3'd1) ? 32'd100 : ((mMode == 3'd4) ? 32'd1000 : 32'd400);
      8'h89: begin w = {29'd0, mMode}; n = 2; end
      default: w = 32'hFFFF_FFFF;
    endcase
    if (mPtr == 8'h80) return dataRdByte;
    if (mIdx >= n) return 8'hFF;
    return w[8*(n-1-mIdx) +: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare registered outputs against the model on every clock
  always @(negedge clk) if (rstN && !done) begin
    check(devAddr == mAddr, "R4 R5 devAddr", 32'(devAddr), 32'(mAddr));
    check(speedMode == mMode, "R4 R8 speedMode", 32'(speedMode), 32'(mMode));
    check(softReset == mSoft, "R6 softReset", 32'(softReset), 32'(mSoft));
  end

  task automatic doStart(); evStart = 1; @(negedge clk); evStart = 0; endtask
  task automatic doStop();  evStop = 1;  @(negedge clk); evStop = 0;  endtask
  task automatic doAddr(input bit rd);
    evAddrMatch = 1; evRead = rd; @(negedge clk); evAddrMatch = 0; evRead = 0;
  endtask
  task automatic wrB(input logic [7:0] b);
    bit expV;
    evWrByte = 1; wrByte = b; #1;
    expV = mAct && !mRd && mHavePtr && mPtr == 8'h80;
    check(dataWrValid == expV, "R2 dataWrValid", 32'(dataWrValid), 32'(expV));
    if (expV) check(dataWrByte == b, "R2 dataWrByte", 32'(dataWrByte), 32'(b));
    @(negedge clk); evWrByte = 0;
  endtask
  task automatic rdB(input string tag, output logic [7:0] got);
    logic [7:0] e; bit expR;
    evRdReq = 1; dataRdByte = dataRdByte + 8'h17; #1;
    e = expRd(); expR = (mPtr == 8'h80);
    got = rdByte;
    check(rdByte == e, tag, 32'(rdByte), 32'(e));
    check(dataRdReq == expR, "R2 dataRdReq", 32'(dataRdReq), 32'(expR));
    @(negedge clk); evRdReq = 0;
  endtask

  task automatic wrReg(input logic [7:0] p, input logic [7:0] b0, input logic [7:0] b1, input int n);
    doStart(); doAddr(0); wrB(p);
    if (n > 0) wrB(b0);
    if (n > 1) wrB(b1);
    doStop();
  endtask

  task automatic rdBurst(input int n, input string tag, output logic [31:0] val);
    logic [7:0] g;
    val = 0;
    for (int i = 0; i < n; i++) begin rdB(tag, g); val = {val[23:0], g}; end
  endtask

  task automatic rdReg(input logic [7:0] p, input int n, input string tag, output logic [31:0] val);
    doStart(); doAddr(0); wrB(p); doStart(); doAddr(1);
    rdBurst(n, tag, val);
    doStop();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(devAddr == 7'h20, "R12 reset devAddr", 32'(devAddr), 32'h20);
    check(speedMode == 3'd3, "R12 reset speedMode", 32'(speedMode), 32'd3);
    check(softReset == 1'b0, "R12 reset softReset", 32'(softReset), 32'd0);

    cmdBusy = 1; respReady = 0; respLen = 16'h1234;
    rdReg(8'h82, 4, "R7 status", v);
    check(v == 32'h8F00_1234, "R7 status word", v, 32'h8F00_1234);
    cmdBusy = 0; respReady = 1; respLen = 16'h00A0;
    rdReg(8'h82, 4, "R7 status", v);
    check(v == 32'h4F00_00A0, "R7 status word 2", v, 32'h4F00_00A0);

    rdReg(8'h81, 3, "R3 R10 len", v);
    check(v == 32'h0001_15FF, "R3 default len and R10 overrun", v, 32'h0001_15FF);
    wrReg(8'h81, 8'h00, 8'h40, 2);
    rdReg(8'h81, 2, "R3 len", v);
    check(v == 32'h0040, "R3 len in range", v, 32'h0040);
    wrReg(8'h81, 8'h00, 8'h05, 2);
    rdReg(8'h81, 2, "R3 len", v);
    check(v == 32'h0010, "R3 len low clamp", v, 32'h0010);
    wrReg(8'h81, 8'hFF, 8'hFF, 2);
    rdReg(8'h81, 2, "R3 len", v);
    check(v == 32'h0115, "R3 len high clamp", v, 32'h0115);
    wrReg(8'h81, 8'h00, 8'h00, 1);
    rdReg(8'h81, 2, "R11 len", v);
    check(v == 32'h0115, "R11 short write ignored", v, 32'h0115);

    // R4: new address not visible until the stop
    doStart(); doAddr(0); wrB(8'h83); wrB(8'h00); wrB(8'h33);
    check(devAddr == 7'h20, "R4 address held mid transfer", 32'(devAddr), 32'h20);
    doStop();
    check(devAddr == 7'h33, "R5 volatile address", 32'(devAddr), 32'h33);
    rdReg(8'h83, 2, "R10 write-only", v);
    check(v == 32'hFFFF, "R10 write-only reads ones", v, 32'hFFFF);

    wrReg(8'h89, 8'h00, 8'h04, 2);
    check(speedMode == 3'd4, "R8 Fm+ mode", 32'(speedMode), 32'd4);
    rdReg(8'h84, 4, "R9 freq", v);
    check(v == 32'd1000, "R9 freq Fm+", v, 32'd1000);
    wrReg(8'h89, 8'h00, 8'h07, 2);
    check(speedMode == 3'd4, "R8 illegal code ignored", 32'(speedMode), 32'd4);
    wrReg(8'h89, 8'h80, 8'h02, 2);
    rdReg(8'h89, 2, "R8 mode", v);
    check(v == 32'h0002, "R8 mode readback bit15 zero", v, 32'h0002);
    doStart(); doAddr(1); rdBurst(2, "R1 pointer kept", v); doStop();
    check(v == 32'h0002, "R1 pointer retained", v, 32'h0002);
    rdReg(8'h84, 4, "R9 freq", v);
    check(v == 32'd400, "R9 freq Fm", v, 32'd400);
    wrReg(8'h89, 8'h00, 8'h01, 2);
    rdReg(8'h84, 4, "R9 freq", v);
    check(v == 32'd100, "R9 freq Sm", v, 32'd100);

    wrReg(8'h83, 8'h80, 8'h45, 2);
    wrReg(8'h83, 8'h00, 8'h11, 2);
    check(devAddr == 7'h11, "R5 volatile over persistent", 32'(devAddr), 32'h11);
    wrReg(8'h81, 8'h00, 8'h40, 2);
    wrReg(8'h88, 8'h00, 8'h00, 1);
    @(negedge clk);
    check(devAddr == 7'h45, "R6 address reload", 32'(devAddr), 32'h45);
    check(speedMode == 3'd2, "R6 mode reload", 32'(speedMode), 32'd2);
    rdReg(8'h81, 2, "R6 len", v);
    check(v == 32'h0115, "R6 len default", v, 32'h0115);
    wrReg(8'h88, 8'h00, 8'h00, 0);
    check(softReset == 1'b0, "R6 no data byte no pulse", 32'(softReset), 32'd0);

    wrReg(8'h82, 8'h12, 8'h34, 2);
    wrReg(8'h84, 8'h00, 8'h01, 2);
    rdReg(8'h84, 4, "R11 freq", v);
    check(v == 32'd400, "R11 read-only freq unchanged", v, 32'd400);
    rdReg(8'h85, 4, "R10 unimpl", v);
    check(v == 32'hFFFF_FFFF, "R10 unimplemented", v, 32'hFFFF_FFFF);

    doStart(); doAddr(0); wrB(8'h80); wrB(8'hA1); wrB(8'hB2); wrB(8'hC3); doStop();
    rdReg(8'h80, 3, "R2 window read", v);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule